// File: doc/BRIEF.md
# Dual-Function Interrupt Steering Unit

This block steers the level-sensitive interrupt requests of two card-socket functions onto the parallel PCI interrupt lines INTA and INTB, which leave the chip on multifunction pins. Each line is active-low and open-drain in style: it is pulled low while its request holds and is otherwise released, modelled here as a logic 1. The block also produces the read-only interrupt pin code that each function returns from its configuration header.

A single tie control from the system control register changes two things at once. It folds the requests of both functions onto INTA and holds INTB released. It also makes both functions report the INTA pin code. A signaling-mode input selects whether the parallel PCI lines are in use at all. They are in use when every interrupt is parallel, or when the serial protocol carries only ISA IRQs. When the serial protocol also carries the PCI interrupts, both lines stay released. Every output is registered, so it reflects the inputs sampled at the previous rising clock edge.

Top module: `irq_steer_top`

## Requirements
- R1: While `rst_n` is low, `int_n` is all ones, `pin_code[7:0]` is 8'h01 and `pin_code[15:8]` is 8'h02.
- R2: With `tie_en` low and `sig_mode` set to 2'b00, `int_n[0]` is low after a rising edge exactly when `fn_req[0]` was high at that edge. `fn_req[1]` has no effect on `int_n[0]`.
- R3: With `tie_en` low and `sig_mode` set to 2'b00, `int_n[1]` is low after a rising edge exactly when `fn_req[1]` was high at that edge. `fn_req[0]` has no effect on `int_n[1]`.
- R4: With `tie_en` high and `sig_mode` set to 2'b00, `int_n[0]` is low after an edge when either request bit was high at that edge, and high when neither was.
- R5: With `tie_en` high, `int_n[1]` is high after the edge, whatever the request and mode inputs are.
- R6: With `tie_en` low, `pin_code[7:0]` is 8'h01 (function 0, INTA) and `pin_code[15:8]` is 8'h02 (function 1, INTB) after the edge, in every mode.
- R7: With `tie_en` high, both bytes of `pin_code` are 8'h01 after the edge, in every mode.
- R8: With `sig_mode` set to 2'b10 (serial carries PCI interrupts) or 2'b11 (reserved, handled the same way), both `int_n` bits are high after the edge, whatever the requests are.
- R9: `sig_mode` 2'b01 (serial carries ISA IRQs only) drives `int_n` exactly as 2'b00 does, for both tie settings.
- R10: Each output changes only at a rising edge and reflects the inputs sampled at that edge. With no request bit set, both lines are high after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fn_req | input | NUM_FN (2) | Level interrupt request of each function; bit 0 is function 0 |
| tie_en | input | 1 | Tie control: merges all requests onto INTA |
| sig_mode | input | 2 | 00 all parallel, 01 serial ISA only, 10 serial all, 11 reserved (as 10) |
| int_n | output | NUM_FN (2) | Active-low PCI interrupt lines; bit 0 INTA, bit 1 INTB |
| pin_code | output | NUM_FN*PIN_W (16) | Interrupt pin code for each function; byte i is function i |

## Verification
The embedded assertions check, on every cycle, the relations that follow from one sampled input set. An asserted request must pull the correct line low. The tie setting must release INTB and force both pin codes to 01h. Full serial mode and an idle request vector must release every line. Some behaviour is visible only in the bench's scenarios, where a behavioural model is compared on every clock. That covers line 1 being independent of function 0 and the reverse, the reset values, and the equivalence of the two modes that enable the parallel lines. It also covers the return of the untied pin codes after the tie is cleared and the absence of any extra latency when inputs change every cycle.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

    typedef enum logic [1:0] {
        SIG_PARALLEL = 2'b00,
        SIG_SER_ISA  = 2'b01,
        SIG_SER_ALL  = 2'b10,
        SIG_SER_RSVD = 2'b11
    } sig_mode_e;

    // Parallel PCI lines are usable unless the serial stream carries them
    function automatic logic pci_lines_enabled(input logic [1:0] mode);
        return (mode == SIG_PARALLEL) || (mode == SIG_SER_ISA);
    endfunction

    // Pin code of the INTA line; line k reports code k+1
    localparam int unsigned PIN_CODE_BASE = 1;

endpackage

// File: rtl/irq_line_merge.sv
module irq_line_merge #(
    parameter int unsigned NUM_FN = 2
) (
    input  logic [NUM_FN-1:0] req,
    input  logic              tie,
    output logic [NUM_FN-1:0] line_req
);
    // Line 0 collects every request when tied; other lines go quiet
    generate
        for (genvar g = 0; g < NUM_FN; g++) begin : g_line
            if (g == 0) begin : g_first
                always_comb line_req[g] = tie ? (|req) : req[g];
            end else begin : g_other
                always_comb line_req[g] = tie ? 1'b0 : req[g];
            end
        end
    endgenerate
endmodule

// File: rtl/irq_pin_code.sv
module irq_pin_code #(
    parameter int unsigned NUM_FN = 2,
    parameter int unsigned PIN_W  = 8
) (
    input  logic                    tie,
    output logic [NUM_FN*PIN_W-1:0] code
);
    import irq_steer_pkg::*;

    generate
        for (genvar g = 0; g < NUM_FN; g++) begin : g_fn
            localparam logic [PIN_W-1:0] OWN_CODE  = PIN_W'(PIN_CODE_BASE + g);
            localparam logic [PIN_W-1:0] TIED_CODE = PIN_W'(PIN_CODE_BASE);
            always_comb code[g*PIN_W +: PIN_W] = tie ? TIED_CODE : OWN_CODE;
        end
    endgenerate
endmodule

// File: rtl/irq_steer_top.sv
module irq_steer_top #(
    parameter int unsigned NUM_FN = 2,
    parameter int unsigned PIN_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_FN-1:0]       fn_req,
    input  logic                    tie_en,
    input  logic [1:0]              sig_mode,
    output logic [NUM_FN-1:0]       int_n,
    output logic [NUM_FN*PIN_W-1:0] pin_code
);
    import irq_steer_pkg::*;

    localparam int unsigned CODE_W = NUM_FN * PIN_W;

    typedef struct packed {
        logic [NUM_FN-1:0] line_n;
        logic [CODE_W-1:0] code;
    } steer_t;

    function automatic logic [CODE_W-1:0] reset_codes();
        logic [CODE_W-1:0] v;
        v = '0;
        for (int i = 0; i < int'(NUM_FN); i++) begin
            v[i*PIN_W +: PIN_W] = PIN_W'(PIN_CODE_BASE + i);
        end
        return v;
    endfunction

    logic [NUM_FN-1:0] line_req;
    logic [CODE_W-1:0] code_next;
    logic              lines_on;
    steer_t            steer_d, steer_q;

    irq_line_merge #(.NUM_FN(NUM_FN)) u_merge (
        .req      (fn_req),
        .tie      (tie_en),
        .line_req (line_req)
    );

    irq_pin_code #(.NUM_FN(NUM_FN), .PIN_W(PIN_W)) u_code (
        .tie  (tie_en),
        .code (code_next)
    );

    always_comb begin
        lines_on       = pci_lines_enabled(sig_mode);
        steer_d        = steer_q;
        steer_d.line_n = lines_on ? ~line_req : '1;
        steer_d.code   = code_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            steer_q.line_n <= '1;
            steer_q.code   <= reset_codes();
        end else begin
            steer_q <= steer_d;
        end
    end

    assign int_n    = steer_q.line_n;
    assign pin_code = steer_q.code;

    AST_FN0_DRIVES_INTA: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_lines_enabled(sig_mode) && !tie_en && fn_req[0]) |=> !int_n[0]); // R2

    AST_TIE_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_lines_enabled(sig_mode) && tie_en && (|fn_req)) |=> !int_n[0]); // R4

    AST_TIE_INTB_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        tie_en |=> (&int_n[NUM_FN-1:1])); // R5

    AST_TIE_PIN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        tie_en |=> (pin_code[PIN_W-1:0] == PIN_W'(1)
                    && pin_code[2*PIN_W-1:PIN_W] == PIN_W'(1))); // R7

    AST_SERIAL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_mode[1]) |=> (&int_n)); // R8

    AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_req == '0) |=> (&int_n)); // R10

endmodule

// File: tb/irq_steer_top_tb_top.sv
module irq_steer_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fn_req = 2'b00;
    logic        tie_en = 1'b0;
    logic [1:0]  sig_mode = 2'b00;
    logic [1:0]  int_n;
    logic [15:0] pin_code;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk; // 125 MHz

    irq_steer_top dut_i (
        .clk(clk), .rst_n(rst_n), .fn_req(fn_req), .tie_en(tie_en),
        .sig_mode(sig_mode), .int_n(int_n), .pin_code(pin_code)
    );

    // Behavioural reference: values expected after the next rising edge
    logic [1:0]  exp_n;
    logic [15:0] exp_code;

    task automatic model(input logic [1:0] rq, input logic t, input logic [1:0] m);
        bit on;
        on = (m == 2'd0) || (m == 2'd1);
        exp_n = 2'b11;
        if (on) begin
            if (t) begin
                if (rq != 2'b00) exp_n[0] = 1'b0;
            end else begin
                exp_n[0] = !rq[0];
                exp_n[1] = !rq[1];
            end
        end
        exp_code = t ? 16'h0101 : 16'h0201;
    endtask

    task automatic check(input string tag);
        n_tests++;
        if (int_n !== exp_n || pin_code !== exp_code) begin
            n_fail++;
            $display("FAIL %s: int_n=%b pin_code=%h expected int_n=%b pin_code=%h",
                     tag, int_n, pin_code, exp_n, exp_code);
        end
    endtask

    // Drive at a falling edge, check at the next falling edge
    task automatic step(input logic [1:0] rq, input logic t, input logic [1:0] m,
                        input string tag);
        fn_req = rq; tie_en = t; sig_mode = m;
        model(rq, t, m);
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        exp_n = 2'b11; exp_code = 16'h0201;
        fn_req = 2'b11; tie_en = 1'b1;
        @(negedge clk);
        check("R1 reset values");
        fn_req = 2'b00; tie_en = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R10: first cycle with no request leaves everything released
        step(2'b00, 1'b0, 2'd0, "R10 idle");
        step(2'b01, 1'b0, 2'd0, "R2 fn0 only");
        step(2'b10, 1'b0, 2'd0, "R3 fn1 only, R2 fn1 ignored on INTA");
        step(2'b11, 1'b0, 2'd0, "R2 R3 both");
        step(2'b01, 1'b0, 2'd0, "R3 fn0 ignored on INTB");
        step(2'b00, 1'b0, 2'd0, "R6 untied codes");
        step(2'b10, 1'b1, 2'd0, "R4 tied fn1 to INTA, R5");
        step(2'b01, 1'b1, 2'd0, "R4 tied fn0");
        step(2'b11, 1'b1, 2'd0, "R5 INTB held released");
        step(2'b00, 1'b1, 2'd0, "R7 tied codes");
        step(2'b11, 1'b1, 2'd2, "R7 tied codes in serial mode, R8");
        step(2'b11, 1'b0, 2'd2, "R8 serial-all releases");
        step(2'b11, 1'b0, 2'd3, "R8 reserved mode releases");
        step(2'b01, 1'b0, 2'd1, "R9 serial ISA-only untied");
        step(2'b10, 1'b1, 2'd1, "R9 serial ISA-only tied");
        step(2'b10, 1'b0, 2'd1, "R6 codes restored after untie");

        // R10: inputs changing every cycle, compared against the model each clock
        for (int i = 0; i < 400; i++) begin
            logic [4:0] v;
            v = 5'((i * 7 + (i >> 3) * 13) % 32);
            step(v[1:0], v[2], v[4:3], "R10 sweep");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule